// File: doc/BRIEF.md
# Register Window Overflow Detector

This block sits ahead of an instruction that needs up to one, two or three groups of four logical registers from a rotating register file. It checks whether those groups would run into a frame that a caller still owns. The file is split into `NWIN` windows of four registers each. A window-start bitmap marks which windows begin a live frame, and a window base names the window the running code currently owns. Looking upward from the base, the block finds the distance `n` to the nearest live window.

When that live window falls inside the space the instruction needs, the block reports an overflow. With the overflow it gives:
- the forward rotation, which equals `n`;
- a processor-status word with the old base saved into its old-base field and the exception-mode bit set;
- the faulting PC as the saved exception PC;
- the overflow class, chosen from how far the next live window lies beyond the one found.

Raising the exception itself belongs to the surrounding pipeline.

A request is presented with `req_valid` high. All result fields are registered and appear together one clock later with `rsp_valid` high. While no request is offered, the result registers keep their last values.

Top module: `wovf_detector`

## Requirements
- R1: After a synchronous reset, `rsp_valid`, `ovf` and `rot_amt` are 0 and `exc_kind` is 0 (no overflow).
- R2: `rsp_valid` is high in the cycle after a cycle with `req_valid` high, and low in the cycle after a cycle with `req_valid` low.
- R3: Let `n` be the smallest d in 1..NWIN for which bit (win_base+d) mod NWIN of `win_start` is set, with no such d when the bitmap is zero. `ovf` is 1 exactly when such an `n` exists and `n <= need_quads`. As a result, `need_quads` = 0 never overflows, and a bitmap with no set bit other than the current window never overflows.
- R4: `rot_amt` equals `n` when `ovf` is 1, and is 0 otherwise.
- R5: When `ovf` is 1, `ps_out` equals `ps_in` with two changes: bits [OWB_LSB+WBW-1:OWB_LSB] replaced by `win_base`, and bit EXCM_BIT set. With the default parameters these are bits [10:8] and bit 4. When `ovf` is 0, `ps_out` equals `ps_in`.
- R6: `epc_out` equals `pc_in` when `ovf` is 1, and is 0 otherwise.
- R7: `exc_kind` has four values:
  - 0 when there is no overflow;
  - 1 (four-register class) if window (win_base+n+1) mod NWIN is live;
  - 2 (eight-register class) if that window is not live and window (win_base+n+2) mod NWIN is live;
  - 3 (twelve-register class) otherwise.
- R8: In a cycle after one with `req_valid` low, `ovf`, `rot_amt`, `ps_out`, `epc_out` and `exc_kind` are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request qualifier |
| win_base | input | WBW = log2(NWIN) | Current window base |
| win_start | input | NWIN | Live-frame bitmap, one bit per window |
| ps_in | input | PSW | Processor status before the check |
| pc_in | input | PCW | PC of the checked instruction |
| need_quads | input | 2 | Register groups of four the instruction needs (0..3) |
| rsp_valid | output | 1 | Result qualifier, one cycle after request |
| ovf | output | 1 | Overflow detected |
| rot_amt | output | 2 | Forward window rotation |
| ps_out | output | PSW | Updated processor status |
| epc_out | output | PCW | Saved exception PC |
| exc_kind | output | 2 | Overflow class: 0 none, 1 four, 2 eight, 3 twelve |

## Verification
The assertions assume that `NWIN` is a power of two of at least 8. Under that assumption the rotated scan always has at least two windows beyond the found frame, so a class decision never reads past the doubled bitmap. They also assume that the processor-status input is driven with known values whenever `req_valid` is high, because the old-base and exception-mode checks compare registered fields against it. The stimulus meets both assumptions. It uses the default eight-window configuration and sweeps every base, every bitmap and every need value, with fully defined status and PC patterns. Requests are interleaved with idle cycles whose inputs are deliberately changed, to test the hold behaviour.

// File: rtl/wovf_pkg.sv
package wovf_pkg;
  typedef enum logic [1:0] {
    KIND_NONE  = 2'd0,
    KIND_OVF4  = 2'd1,
    KIND_OVF8  = 2'd2,
    KIND_OVF12 = 2'd3
  } ovf_kind_e;
endpackage

// File: rtl/wovf_ctz.sv
module wovf_ctz #(
  parameter int W  = 16,
  parameter int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] cnt,
  output logic          all_zero
);
  // Priority scan from the top bit down; the lowest set bit wins.
  always_comb begin
    cnt = CW'(W);
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) cnt = CW'(i);
    end
  end

  assign all_zero = ~|vec;
endmodule

// File: rtl/wovf_scan.sv
module wovf_scan
  import wovf_pkg::*;
#(
  parameter int NWIN = 8,
  parameter int WBW  = $clog2(NWIN)
) (
  input  logic [WBW-1:0]  base,
  input  logic [NWIN-1:0] ws,
  input  logic [1:0]      need,
  output logic            hit,
  output logic [1:0]      n_rot,
  output ovf_kind_e       kind
);
  localparam int DW = 2 * NWIN;
  localparam int CW = $clog2(DW + 1);

  logic [DW-1:0]  dbl, sh1, sh2;
  logic [WBW:0]   sh_amt;
  logic [CW-1:0]  c1, c2;
  logic           z1, z2;
  logic [CW:0]    n_full;

  // Doubled bitmap, moved so bit 0 is the window just above the base.
  assign dbl    = {ws, ws};
  assign sh_amt = (WBW+1)'(base) + (WBW+1)'(1);
  assign sh1    = dbl >> sh_amt;

  wovf_ctz #(.W(DW), .CW(CW)) u_first (
    .vec(sh1), .cnt(c1), .all_zero(z1)
  );

  assign n_full = (CW+1)'(c1) + (CW+1)'(1);
  assign hit    = !z1 && (n_full <= (CW+1)'(need));
  assign n_rot  = hit ? n_full[1:0] : 2'd0;

  // Look past the found frame to classify the overflow.
  assign sh2 = sh1 >> n_rot;

  wovf_ctz #(.W(DW), .CW(CW)) u_second (
    .vec(sh2), .cnt(c2), .all_zero(z2)
  );

  always_comb begin
    if (!hit)                 kind = KIND_NONE;
    else if (c2 == CW'(0))    kind = KIND_OVF4;
    else if (c2 == CW'(1))    kind = KIND_OVF8;
    else                      kind = KIND_OVF12;
  end

  logic unused_z2;
  assign unused_z2 = z2;
endmodule

// File: rtl/wovf_psbuild.sv
module wovf_psbuild #(
  parameter int PSW      = 32,
  parameter int WBW      = 3,
  parameter int OWB_LSB  = 8,
  parameter int EXCM_BIT = 4
) (
  input  logic [PSW-1:0] ps_in,
  input  logic [WBW-1:0] base,
  input  logic           ovf,
  output logic [PSW-1:0] ps_out
);
  always_comb begin
    ps_out = ps_in;
    if (ovf) begin
      ps_out[OWB_LSB +: WBW] = base;
      ps_out[EXCM_BIT]       = 1'b1;
    end
  end
endmodule

// File: rtl/wovf_detector.sv
module wovf_detector
  import wovf_pkg::*;
#(
  parameter int NWIN     = 8,
  parameter int PSW      = 32,
  parameter int PCW      = 32,
  parameter int OWB_LSB  = 8,
  parameter int EXCM_BIT = 4,
  localparam int WBW     = $clog2(NWIN)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  input  logic [WBW-1:0]  win_base,
  input  logic [NWIN-1:0] win_start,
  input  logic [PSW-1:0]  ps_in,
  input  logic [PCW-1:0]  pc_in,
  input  logic [1:0]      need_quads,
  output logic            rsp_valid,
  output logic            ovf,
  output logic [1:0]      rot_amt,
  output logic [PSW-1:0]  ps_out,
  output logic [PCW-1:0]  epc_out,
  output logic [1:0]      exc_kind
);
  generate
    if (NWIN < 8 || (1 << WBW) != NWIN) begin : g_bad_nwin
      $error("NWIN must be a power of two of at least 8");
    end
    if (OWB_LSB + WBW > PSW || EXCM_BIT >= PSW) begin : g_bad_ps
      $error("status field positions exceed PSW");
    end
  endgenerate

  logic            hit_c;
  logic [1:0]      rot_c;
  ovf_kind_e       kind_c;
  logic [PSW-1:0]  ps_c;

  wovf_scan #(.NWIN(NWIN), .WBW(WBW)) u_scan (
    .base(win_base), .ws(win_start), .need(need_quads),
    .hit(hit_c), .n_rot(rot_c), .kind(kind_c)
  );

  wovf_psbuild #(.PSW(PSW), .WBW(WBW), .OWB_LSB(OWB_LSB), .EXCM_BIT(EXCM_BIT)) u_ps (
    .ps_in(ps_in), .base(win_base), .ovf(hit_c), .ps_out(ps_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      ovf       <= 1'b0;
      rot_amt   <= 2'd0;
      ps_out    <= '0;
      epc_out   <= '0;
      exc_kind  <= KIND_NONE;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        ovf      <= hit_c;
        rot_amt  <= rot_c;
        ps_out   <= ps_c;
        epc_out  <= hit_c ? pc_in : '0;
        exc_kind <= kind_c;
      end
    end
  end

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  // R2
  valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);
  // R3
  ovf_need_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && need_quads == 2'd0) |=> !ovf);
  // R4
  rot_range_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (ovf == (rot_amt != 2'd0)));
  // R5
  excm_set_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && ovf) |-> (ps_out[EXCM_BIT] && ps_out[OWB_LSB +: WBW] == $past(win_base)));
  // R6
  epc_capture_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && ovf) |-> epc_out == $past(pc_in));
  // R7
  kind_consistent_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (ovf == (exc_kind != 2'd0)));
  // R8
  hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> ($stable(ps_out) && $stable(epc_out) && $stable(exc_kind) && $stable(ovf)));
endmodule

// File: tb/sim_wovf_detector.sv
`timescale 1ns/1ps
module sim_wovf_detector;
  localparam int NWIN = 8;
  localparam int WBW  = 3;

  logic            clk = 1'b0;
  logic            rst;
  logic            req_valid;
  logic [WBW-1:0]  win_base;
  logic [NWIN-1:0] win_start;
  logic [31:0]     ps_in, pc_in;
  logic [1:0]      need_quads;
  logic            rsp_valid, ovf;
  logic [1:0]      rot_amt, exc_kind;
  logic [31:0]     ps_out, epc_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  wovf_detector #(.NWIN(NWIN)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .win_base(win_base),
    .win_start(win_start), .ps_in(ps_in), .pc_in(pc_in), .need_quads(need_quads),
    .rsp_valid(rsp_valid), .ovf(ovf), .rot_amt(rot_amt), .ps_out(ps_out),
    .epc_out(epc_out), .exc_kind(exc_kind)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  logic        e_ovf;
  logic [1:0]  e_rot, e_kind;
  logic [31:0] e_ps, e_epc;

  task automatic model(input int b, input int ws, input int need, input logic [31:0] ps,
                       input logic [31:0] pc);
    int n = 0;
    for (int d = 1; d <= NWIN; d++) begin
      if (n == 0 && ws[(b + d) % NWIN]) n = d;
    end
    e_ovf = (n != 0) && (n <= need);
    e_rot = e_ovf ? 2'(n) : 2'd0;
    e_ps  = ps;
    e_epc = 32'd0;
    e_kind = 2'd0;
    if (e_ovf) begin
      e_ps = (ps & ~(32'h7 << 8)) | (32'(b) << 8) | 32'h10;
      e_epc = pc;
      if (ws[(b + n + 1) % NWIN])      e_kind = 2'd1;
      else if (ws[(b + n + 2) % NWIN]) e_kind = 2'd2;
      else                             e_kind = 2'd3;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int idx = 0;
    rst = 1'b1; req_valid = 1'b0; win_base = '0; win_start = '0;
    ps_in = '0; pc_in = '0; need_quads = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 rsp_valid", 64'(rsp_valid), 64'd0);
    chk("R1 ovf", 64'(ovf), 64'd0);
    chk("R1 rot_amt", 64'(rot_amt), 64'd0);
    chk("R1 exc_kind", 64'(exc_kind), 64'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R2 idle after reset", 64'(rsp_valid), 64'd0);

    for (int b = 0; b < NWIN; b++) begin
      for (int ws = 0; ws < (1 << NWIN); ws++) begin
        for (int need = 0; need < 4; need++) begin
          logic [31:0] ps, pc;
          ps = 32'hA5C3_0F6E ^ (32'(ws) * 32'h0101_0101) ^ 32'(idx * 7);
          pc = 32'h4000_0000 + 32'(idx * 4);
          req_valid = 1'b1; win_base = WBW'(b); win_start = NWIN'(ws);
          ps_in = ps; pc_in = pc; need_quads = 2'(need);
          model(b, ws, need, ps, pc);
          @(negedge clk);
          chk("R2 rsp_valid", 64'(rsp_valid), 64'd1);
          chk("R3 ovf", 64'(ovf), 64'(e_ovf));
          chk("R4 rot_amt", 64'(rot_amt), 64'(e_rot));
          chk("R5 ps_out", 64'(ps_out), 64'(e_ps));
          chk("R6 epc_out", 64'(epc_out), 64'(e_epc));
          chk("R7 exc_kind", 64'(exc_kind), 64'(e_kind));
          if ((idx % 61) == 0) begin
            // R8 idle cycle with changed inputs must not disturb results
            req_valid = 1'b0; win_start = ~win_start; win_base = win_base + 1'b1;
            ps_in = ~ps_in; pc_in = ~pc_in; need_quads = 2'd3;
            @(negedge clk);
            chk("R2 idle rsp_valid", 64'(rsp_valid), 64'd0);
            chk("R8 hold ovf", 64'(ovf), 64'(e_ovf));
            chk("R8 hold ps_out", 64'(ps_out), 64'(e_ps));
            chk("R8 hold epc_out", 64'(epc_out), 64'(e_epc));
            chk("R8 hold exc_kind", 64'(exc_kind), 64'(e_kind));
            chk("R8 hold rot_amt", 64'(rot_amt), 64'(e_rot));
          end
          idx++;
        end
      end
    end

    req_valid = 1'b0;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R1 reset again rsp_valid", 64'(rsp_valid), 64'd0);
    chk("R1 reset again exc_kind", 64'(exc_kind), 64'd0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule